// File: doc/BRIEF.md
# Inclusive Coherence Directory with Per-Port Presence Tracking

This block is a set-associative tag directory placed in front of a group of coherent master ports. It records, for every cache line that any attached master may hold, the line address and a presence vector with one bit per port. Coherent requests query it on the lookup port. A miss means no master holds the line, so the request goes to memory and no master is snooped. A hit returns only the ports whose presence bit is set, so snoops are not broadcast to every port.

The directory follows the masters' caches by watching their traffic on the update port. A fill transaction allocates an entry or adds a holder to an existing one. A clean-drop transaction removes a holder, and the entry is freed when no holder is left. The directory is inclusive. When a new line maps to a set whose eight ways are all valid, one entry is displaced and a clean-and-invalidate request goes out on the back-invalidation port to every holder of the displaced line. The directory is sized at twice a nominal line count to make such conflicts rare.

Top module: `snoop_dir`

## Requirements
- R1: After synchronous reset the directory is empty. `lk_rsp_valid` and `binv_valid` are 0, `up_ready` is 1, and every lookup misses.
- R2: A lookup presented in cycle N gets its response in cycle N+1 (`lk_rsp_valid`=1). For an address with no valid entry, the response has `lk_rsp_hit`=0 and `lk_rsp_targets`=0.
- R3: A lookup of a tracked address returns `lk_rsp_hit`=1. Its `lk_rsp_targets` bit i is 1 exactly when port i has allocated the line and not dropped it.
- R4: An update with `up_op`=0 (allocate) for an address that already has an entry only sets the requesting port's bit. It uses no new way, so it never causes a displacement.
- R5: An update with `up_op`=1 (drop) clears the requesting port's bit. When the last bit clears, the entry is freed and later lookups of that address miss.
- R6: A drop for an address with no entry, or from a port whose bit is clear, leaves every lookup result unchanged.
- R7: An allocate of an untracked address into a set with all 8 ways valid replaces one entry. In the next cycle `binv_valid`=1, `binv_addr` is the displaced line address and `binv_targets` is its presence vector. The displaced address then misses and the new one hits.
- R8: Free ways are filled lowest index first. Each set keeps a round-robin victim pointer that starts at way 0 and advances by one after each displacement in that set. The first displacement in a set therefore removes the line that filled way 0, and the second removes the line in way 1.
- R9: While `binv_valid`=1 and `binv_ready`=0, `binv_addr` and `binv_targets` hold steady. During that time `up_ready`=0 for any allocate into the pending set, and for any allocate that would itself need a displacement. Other updates are accepted.
- R10: The capacity is 2×`NOMINAL_LINES` entries in 8 ways per set. The set index is the low log2(sets) bits of the line address (3 bits by default), and the rest forms the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Line address to look up |
| lk_rsp_valid | output | 1 | Lookup response strobe, one cycle after request |
| lk_rsp_hit | output | 1 | Line is tracked |
| lk_rsp_targets | output | NUM_PORTS | Ports to snoop on a hit |
| up_valid | input | 1 | Observed master transaction |
| up_op | input | 1 | 0 = allocate (fill), 1 = drop (clean evict) |
| up_port | input | PORT_W | Issuing master port |
| up_addr | input | ADDR_W | Line address of the transaction |
| up_ready | output | 1 | Update can be accepted this cycle |
| binv_valid | output | 1 | Back-invalidation request pending |
| binv_addr | output | ADDR_W | Displaced line address |
| binv_targets | output | NUM_PORTS | Ports to clean and invalidate |
| binv_ready | input | 1 | Back-invalidation accepted |

## Verification
On every cycle, the assertions check the one-cycle lookup latency and the agreement between hit and target vector (a miss never names a port, a hit always names one). They also check that a pending back-invalidation stays stable and never has an empty target list, and that an allocate into a pending set is held off. Other properties depend on stored contents over long sequences, so only the directed scenarios show them: which port bits an entry holds, freeing on the last drop, that a repeated allocate does not consume a way, round-robin victim order, and the set/tag split of the address.

// File: rtl/snoop_dir_pkg.sv
package snoop_dir_pkg;

    localparam int SD_PORTS   = 4;
    localparam int SD_ADDR_W  = 16;
    localparam int SD_NOMINAL = 32;
    localparam int SD_WAYS    = 8;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_DROP  = 1'b1
    } sd_op_e;

    function automatic int sd_capacity(input int nominal);
        return 2 * nominal;
    endfunction

    function automatic int sd_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sd_first_one.sv
module sd_first_one #(
    parameter int W   = 8,
    localparam int IW = snoop_dir_pkg::sd_idx_w(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sd_set_match.sv
module sd_set_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 13,
    parameter int NP    = 4,
    localparam int WW   = snoop_dir_pkg::sd_idx_w(WAYS)
) (
    input  logic [WAYS-1:0]            row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [WAYS-1:0][NP-1:0]    row_pres,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       hit,
    output logic [WW-1:0]              hit_way,
    output logic [NP-1:0]              hit_pres,
    output logic                       free_any,
    output logic [WW-1:0]              free_way
);
    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = row_vld[w] && (row_tag[w] == tag_in);
    end

    sd_first_one #(.W(WAYS)) u_hit_pick (
        .vec(way_hit), .found(hit), .idx(hit_way)
    );

    sd_first_one #(.W(WAYS)) u_free_pick (
        .vec(~row_vld), .found(free_any), .idx(free_way)
    );

    assign hit_pres = hit ? row_pres[hit_way] : '0;
endmodule

// File: rtl/sd_binv_slot.sv
module sd_binv_slot #(
    parameter int ADDR_W = 16,
    parameter int NP     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [NP-1:0]     load_tgt,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [NP-1:0]     tgt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            tgt   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= load_addr;
            tgt   <= load_tgt;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/snoop_dir.sv
module snoop_dir #(
    parameter int NUM_PORTS     = snoop_dir_pkg::SD_PORTS,
    parameter int ADDR_W        = snoop_dir_pkg::SD_ADDR_W,
    parameter int NOMINAL_LINES = snoop_dir_pkg::SD_NOMINAL,
    parameter int WAYS          = snoop_dir_pkg::SD_WAYS,
    localparam int PORT_W       = snoop_dir_pkg::sd_idx_w(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [ADDR_W-1:0]    lk_addr,
    output logic                 lk_rsp_valid,
    output logic                 lk_rsp_hit,
    output logic [NUM_PORTS-1:0] lk_rsp_targets,
    input  logic                 up_valid,
    input  logic                 up_op,
    input  logic [PORT_W-1:0]    up_port,
    input  logic [ADDR_W-1:0]    up_addr,
    output logic                 up_ready,
    output logic                 binv_valid,
    output logic [ADDR_W-1:0]    binv_addr,
    output logic [NUM_PORTS-1:0] binv_targets,
    input  logic                 binv_ready
);
    import snoop_dir_pkg::*;

    localparam int ENTRIES = sd_capacity(NOMINAL_LINES);
    localparam int SETS    = ENTRIES / WAYS;
    localparam int SET_W   = sd_idx_w(SETS);
    localparam int TAG_W   = ADDR_W - SET_W;
    localparam int WAY_W   = sd_idx_w(WAYS);
    localparam int NP      = NUM_PORTS;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
    } line_addr_t;

    logic [SETS-1:0][WAYS-1:0]            vld_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][NP-1:0]    pres_q;
    logic [SETS-1:0][WAY_W-1:0]           rr_q;

    // lookup path
    line_addr_t       lk_la;
    logic             l_hit, l_free;
    logic [WAY_W-1:0] l_way, l_fway;
    logic [NP-1:0]    l_pres;

    assign lk_la = line_addr_t'(lk_addr);

    sd_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .NP(NP)) u_lk_match (
        .row_vld (vld_q[lk_la.set]),
        .row_tag (tag_q[lk_la.set]),
        .row_pres(pres_q[lk_la.set]),
        .tag_in  (lk_la.tag),
        .hit     (l_hit),
        .hit_way (l_way),
        .hit_pres(l_pres),
        .free_any(l_free),
        .free_way(l_fway)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rsp_valid   <= 1'b0;
            lk_rsp_hit     <= 1'b0;
            lk_rsp_targets <= '0;
        end else begin
            lk_rsp_valid   <= lk_valid;
            lk_rsp_hit     <= lk_valid && l_hit;
            lk_rsp_targets <= (lk_valid && l_hit) ? l_pres : '0;
        end
    end

    // update path
    line_addr_t       up_la, victim_la, pend_la;
    sd_op_e           op;
    logic             u_hit, u_free, need_evict, is_alloc, accept, binv_load;
    logic [WAY_W-1:0] u_way, u_fway, victim_way;
    logic [NP-1:0]    u_pres, port_bit, drop_pres;

    assign up_la      = line_addr_t'(up_addr);
    assign pend_la    = line_addr_t'(binv_addr);
    assign op         = sd_op_e'(up_op);
    assign is_alloc   = (op == OP_ALLOC);
    assign port_bit   = NP'(1) << up_port;

    sd_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .NP(NP)) u_up_match (
        .row_vld (vld_q[up_la.set]),
        .row_tag (tag_q[up_la.set]),
        .row_pres(pres_q[up_la.set]),
        .tag_in  (up_la.tag),
        .hit     (u_hit),
        .hit_way (u_way),
        .hit_pres(u_pres),
        .free_any(u_free),
        .free_way(u_fway)
    );

    assign need_evict    = !u_hit && !u_free;
    assign victim_way    = rr_q[up_la.set];
    assign victim_la.tag = tag_q[up_la.set][victim_way];
    assign victim_la.set = up_la.set;
    assign drop_pres     = u_pres & ~port_bit;

    assign up_ready  = !(is_alloc && binv_valid &&
                         ((up_la.set == pend_la.set) || need_evict));
    assign accept    = up_valid && up_ready;
    assign binv_load = accept && is_alloc && need_evict;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            tag_q  <= '0;
            pres_q <= '0;
            rr_q   <= '0;
        end else if (accept) begin
            if (is_alloc) begin
                if (u_hit) begin
                    pres_q[up_la.set][u_way] <= u_pres | port_bit;
                end else if (u_free) begin
                    vld_q[up_la.set][u_fway]  <= 1'b1;
                    tag_q[up_la.set][u_fway]  <= up_la.tag;
                    pres_q[up_la.set][u_fway] <= port_bit;
                end else begin
                    tag_q[up_la.set][victim_way]  <= up_la.tag;
                    pres_q[up_la.set][victim_way] <= port_bit;
                    rr_q[up_la.set] <= (victim_way == WAY_W'(WAYS - 1))
                                       ? '0 : victim_way + WAY_W'(1);
                end
            end else if (u_hit && |(u_pres & port_bit)) begin
                pres_q[up_la.set][u_way] <= drop_pres;
                if (drop_pres == '0) vld_q[up_la.set][u_way] <= 1'b0;
            end
        end
    end

    sd_binv_slot #(.ADDR_W(ADDR_W), .NP(NP)) u_binv (
        .clk      (clk),
        .rst      (rst),
        .load     (binv_load),
        .load_addr(ADDR_W'(victim_la)),
        .load_tgt (pres_q[up_la.set][victim_way]),
        .ready    (binv_ready),
        .valid    (binv_valid),
        .addr     (binv_addr),
        .tgt      (binv_targets)
    );
endmodule

// File: rtl/snoop_dir_checker.sv
module snoop_dir_checker #(
    parameter int NP     = 4,
    parameter int ADDR_W = 16,
    parameter int SET_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_rsp_valid,
    input logic              lk_rsp_hit,
    input logic [NP-1:0]     lk_rsp_targets,
    input logic              up_valid,
    input logic              up_op,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_ready,
    input logic              binv_valid,
    input logic [ADDR_W-1:0] binv_addr,
    input logic [NP-1:0]     binv_targets,
    input logic              binv_ready
);
    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_rsp_valid);

    // R2
    miss_no_targets_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && !lk_rsp_hit) |-> (lk_rsp_targets == '0));

    // R3
    hit_has_holder_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && lk_rsp_hit) |-> (lk_rsp_targets != '0));

    // R7
    binv_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        binv_valid |-> (binv_targets != '0));

    // R9
    binv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (binv_valid && !binv_ready) |=>
            (binv_valid && $stable(binv_addr) && $stable(binv_targets)));

    // R9
    set_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (binv_valid && up_valid && !up_op &&
         (up_addr[SET_W-1:0] == binv_addr[SET_W-1:0])) |-> !up_ready);
endmodule

bind snoop_dir snoop_dir_checker #(.NP(NUM_PORTS), .ADDR_W(ADDR_W), .SET_W(SET_W)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_hit(lk_rsp_hit), .lk_rsp_targets(lk_rsp_targets),
    .up_valid(up_valid), .up_op(up_op), .up_addr(up_addr), .up_ready(up_ready),
    .binv_valid(binv_valid), .binv_addr(binv_addr), .binv_targets(binv_targets),
    .binv_ready(binv_ready)
);

// File: tb/tb_snoop_dir.sv
module tb_snoop_dir;
    localparam int NP = 4;
    localparam int AW = 16;
    localparam int SETS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_rsp_valid, lk_rsp_hit;
    logic [NP-1:0] lk_rsp_targets;
    logic          up_valid = 1'b0;
    logic          up_op = 1'b0;
    logic [1:0]    up_port = '0;
    logic [AW-1:0] up_addr = '0;
    logic          up_ready;
    logic          binv_valid;
    logic [AW-1:0] binv_addr;
    logic [NP-1:0] binv_targets;
    logic          binv_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    snoop_dir dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit),
        .lk_rsp_targets(lk_rsp_targets),
        .up_valid(up_valid), .up_op(up_op), .up_port(up_port),
        .up_addr(up_addr), .up_ready(up_ready),
        .binv_valid(binv_valid), .binv_addr(binv_addr),
        .binv_targets(binv_targets), .binv_ready(binv_ready)
    );

    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return AW'(tag * SETS + set);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic upd(input bit op, input int port, input logic [AW-1:0] a);
        @(negedge clk);
        up_valid = 1'b1; up_op = op; up_port = 2'(port); up_addr = a;
        @(posedge clk);
        #1 up_valid = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a, input bit eh, input int et, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(posedge clk);
        #1 lk_valid = 1'b0;
        @(negedge clk);
        chk(lk_rsp_valid == 1'b1, req, int'(lk_rsp_valid), 1);
        chk(lk_rsp_hit == eh, req, int'(lk_rsp_hit), int'(eh));
        chk(lk_rsp_targets == NP'(et), req, int'(lk_rsp_targets), et);
    endtask

    task automatic drain_binv();
        @(negedge clk);
        binv_ready = 1'b1;
        @(posedge clk);
        #1 binv_ready = 1'b0;
        @(negedge clk);
        chk(binv_valid == 1'b0, "R9 drain", int'(binv_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(lk_rsp_valid == 1'b0, "R1 rsp idle", int'(lk_rsp_valid), 0);
        chk(binv_valid == 1'b0, "R1 binv idle", int'(binv_valid), 0);
        chk(up_ready == 1'b1, "R1 ready", int'(up_ready), 1);
        look(mk(7, 3), 1'b0, 0, "R1 R2 empty miss");
    endtask

    task automatic t_holders();
        upd(1'b0, 0, mk(1, 2));
        upd(1'b0, 2, mk(1, 2));
        look(mk(1, 2), 1'b1, 4'b0101, "R3 R4 two holders");
        upd(1'b1, 0, mk(1, 2));
        look(mk(1, 2), 1'b1, 4'b0100, "R5 one dropped");
        upd(1'b1, 3, mk(1, 2));
        look(mk(1, 2), 1'b1, 4'b0100, "R6 non-holder drop");
        upd(1'b1, 1, mk(9, 2));
        look(mk(9, 2), 1'b0, 0, "R6 untracked drop");
        look(mk(1, 2), 1'b1, 4'b0100, "R6 neighbour kept");
        upd(1'b1, 2, mk(1, 2));
        look(mk(1, 2), 1'b0, 0, "R5 last holder frees");
    endtask

    task automatic t_alias();
        upd(1'b0, 3, mk(3, 0));
        look(mk(3, 1), 1'b0, 0, "R10 other set");
        look(mk(4, 0), 1'b0, 0, "R10 other tag");
        look(mk(3, 0), 1'b1, 4'b1000, "R10 own line");
    endtask

    task automatic t_conflict();
        for (int t = 10; t < 18; t++) upd(1'b0, 1, mk(t, 5));
        upd(1'b0, 3, mk(10, 5));
        @(negedge clk);
        chk(binv_valid == 1'b0, "R4 no way consumed", int'(binv_valid), 0);
        upd(1'b0, 0, mk(20, 5));
        @(negedge clk);
        chk(binv_valid == 1'b1, "R7 binv raised", int'(binv_valid), 1);
        chk(binv_addr == mk(10, 5), "R8 first victim way0", int'(binv_addr), int'(mk(10, 5)));
        chk(binv_targets == 4'b1010, "R7 victim holders", int'(binv_targets), 4'b1010);
        look(mk(10, 5), 1'b0, 0, "R7 victim gone");
        look(mk(20, 5), 1'b1, 4'b0001, "R7 new line");
        look(mk(11, 5), 1'b1, 4'b0010, "R7 others kept");
        @(negedge clk);
        up_valid = 1'b1; up_op = 1'b0; up_port = 2'd2; up_addr = mk(21, 5);
        #1 chk(up_ready == 1'b0, "R9 set stall", int'(up_ready), 0);
        up_valid = 1'b0;
        @(negedge clk);
        up_valid = 1'b1; up_op = 1'b0; up_port = 2'd1; up_addr = mk(0, 4);
        #1 chk(up_ready == 1'b1, "R9 other set ready", int'(up_ready), 1);
        up_valid = 1'b0;
        upd(1'b0, 0, mk(1, 6));
        look(mk(1, 6), 1'b1, 4'b0001, "R9 other set accepted");
        chk(binv_valid == 1'b1, "R9 held", int'(binv_valid), 1);
        chk(binv_addr == mk(10, 5), "R9 addr stable", int'(binv_addr), int'(mk(10, 5)));
        drain_binv();
        upd(1'b0, 2, mk(21, 5));
        @(negedge clk);
        chk(binv_valid == 1'b1, "R8 second eviction", int'(binv_valid), 1);
        chk(binv_addr == mk(11, 5), "R8 second victim way1", int'(binv_addr), int'(mk(11, 5)));
        chk(binv_targets == 4'b0010, "R8 second holders", int'(binv_targets), 4'b0010);
        drain_binv();
        look(mk(21, 5), 1'b1, 4'b0100, "R7 second new line");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_holders();
        t_alias();
        t_conflict();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule